// File: doc/BRIEF.md
# SRAM Pattern Self-Test Engine

This block is a test sequencer for an attached static RAM. It reaches the memory only through a simple synchronous request port: a one-cycle request carrying address, write flag and write data, answered later by a completion strobe that brings read data with it. A pulse on `start` runs three passes over the address range `FIRST_ADDR..LAST_ADDR`. Each pass writes every location in ascending order and then reads every location back in ascending order, comparing each read against the value that was written.

The first pass places a single set bit in each word. The second and third passes use alternating-bit words, with opposite phase between them, so every cell holds both values once. If a pass finds any mismatch, the engine finishes that pass and then stops. It reports a pass/fail verdict, the first failing address with its expected and actual data, a mask of every bit that miscompared, and a coarse fault class. These results stay on the outputs until the next start.

The sequencer has seven states. IDLE goes to WR_REQ on start. WR_REQ always goes to WR_WAIT. WR_WAIT goes back to WR_REQ on a completion (next address), or to RD_REQ on the completion of the last address. RD_REQ always goes to RD_WAIT. RD_WAIT goes back to RD_REQ on a completion, or to PASS_END on the completion of the last address. PASS_END goes to WR_REQ (next pass) when the pass was clean and another pass follows. Otherwise PASS_END goes to FINISH. FINISH always returns to IDLE.

Top module: `mem_pattern_tester`

## Requirements
- R1: A `start` pulse in IDLE launches a test; `start` seen while a test runs is ignored (one done pulse, unchanged request count).
- R2: In the first pass, address a is written with only bit (a mod DATA_W) set, e.g. 0x01 at 0, 0x02 at 1, 0x20 at 5.
- R3: The second pass writes 0xAA to even and 0x55 to odd addresses; the third writes 0x55 to even and 0xAA to odd addresses; each pass writes all addresses in ascending order before reading them all in ascending order.
- R4: Only one request is outstanding: `req_valid` is high for one cycle, and no new request is issued until `mem_done` has been seen.
- R5: When all three passes compare clean, `result_pass`=1 and `result_fail`=0 after 3×2×N requests (N = number of addresses); the two verdicts are never both high.
- R6: A pass that sees any mismatch runs to its end, and then the test stops with `result_fail`=1, with no further pass.
- R7: `fail_addr`, `fail_expected` and `fail_actual` capture only the first mismatching read.
- R8: `fail_bits` is the OR of expected XOR actual over all mismatching reads.
- R9: `fault_class` is 2'b00 with no mismatch; 2'b10 (single cell) when exactly one read failed; 2'b01 (stuck data bit) when two or more failed and one bit position is wrong in all of them; 2'b11 (address or other) otherwise.
- R10: `done` is high for exactly one cycle at the end; the verdict and captured fields hold until the next start, which clears them.
- R11: After reset, `req_valid`, `done`, `result_pass` and `result_fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a test (honoured only in IDLE) |
| req_valid | output | 1 | One-cycle memory request |
| req_write | output | 1 | 1 = write request, 0 = read request |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | DATA_W | Write data (the expected pattern) |
| mem_done | input | 1 | Completion of the outstanding request |
| mem_rdata | input | DATA_W | Read data, valid with `mem_done` |
| done | output | 1 | End-of-test pulse |
| result_pass | output | 1 | All passes clean |
| result_fail | output | 1 | A mismatch was seen |
| fail_addr | output | ADDR_W | First failing address |
| fail_expected | output | DATA_W | Expected data of first failure |
| fail_actual | output | DATA_W | Read data of first failure |
| fail_bits | output | DATA_W | OR of all miscompare bit masks |
| fault_class | output | 2 | Fault class code (see R9) |

## Verification
The bench drives a memory model that can hold a stuck data line, one bad cell or an ignored address bit, and it varies the completion latency. The cell faults are chosen so that some appear only in the second or third pass. An engine with the checkerboard phases swapped or the passes out of order would report the wrong pass, address or request count. A stuck line must be told apart from a cell fault and from aliasing: an engine that ANDed the bit errors over all reads instead of over failing reads would never report a stuck bit. The bench also pokes `start` mid-run and watches the results after done, which catches an engine that restarts or lets its verdict drift.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

    typedef enum logic [1:0] {
        PASS_WALK  = 2'd0,
        PASS_CHK_A = 2'd1,
        PASS_CHK_B = 2'd2
    } pass_e;

    typedef enum logic [1:0] {
        FC_NONE       = 2'b00,
        FC_STUCK_BIT  = 2'b01,
        FC_ONE_CELL   = 2'b10,
        FC_ADDR_OTHER = 2'b11
    } fault_e;

endpackage

// File: rtl/mpt_pattern_gen.sv
module mpt_pattern_gen
    import mpt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  pass_e              pass_sel,
    input  logic [ADDR_W-1:0]  addr,
    output logic [DATA_W-1:0]  exp_data
);

    logic [DATA_W-1:0] walk_word;
    logic [DATA_W-1:0] hi_word;   // odd bit positions set (0xAA at 8 bits)
    logic [DATA_W-1:0] lo_word;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bits
        assign walk_word[b] = ((32'(addr) % DATA_W) == b);
        assign hi_word[b]   = ((b % 2) == 1);
    end
    assign lo_word = ~hi_word;

    always_comb begin
        unique case (pass_sel)
            PASS_WALK:  exp_data = walk_word;
            PASS_CHK_A: exp_data = addr[0] ? lo_word : hi_word;
            PASS_CHK_B: exp_data = addr[0] ? hi_word : lo_word;
            default:    exp_data = '0;
        endcase
    end

endmodule

// File: rtl/mpt_fault_log.sv
module mpt_fault_log
    import mpt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               cmp_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  exp_data,
    input  logic [DATA_W-1:0]  act_data,
    output logic               any_fail,
    output logic [ADDR_W-1:0]  first_addr,
    output logic [DATA_W-1:0]  first_exp,
    output logic [DATA_W-1:0]  first_act,
    output logic [DATA_W-1:0]  or_mask,
    output fault_e             fclass
);

    logic [DATA_W-1:0] diff;
    logic [DATA_W-1:0] and_mask;   // bits wrong in every failing read
    logic [1:0]        fail_cnt;   // saturates at 2
    logic              seen;

    assign diff = exp_data ^ act_data;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen       <= 1'b0;
            fail_cnt   <= '0;
            first_addr <= '0;
            first_exp  <= '0;
            first_act  <= '0;
            or_mask    <= '0;
            and_mask   <= '1;
        end else if (cmp_en && (diff != '0)) begin
            if (!seen) begin
                first_addr <= addr;
                first_exp  <= exp_data;
                first_act  <= act_data;
            end
            seen     <= 1'b1;
            or_mask  <= or_mask | diff;
            and_mask <= and_mask & diff;
            if (fail_cnt != 2'd2) fail_cnt <= fail_cnt + 2'd1;
        end
    end

    assign any_fail = seen;

    always_comb begin
        if (fail_cnt == 2'd0)      fclass = FC_NONE;
        else if (fail_cnt == 2'd1) fclass = FC_ONE_CELL;
        else if (and_mask != '0)   fclass = FC_STUCK_BIT;
        else                       fclass = FC_ADDR_OTHER;
    end

    AST_FIRST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !clr) |=> ($stable(first_addr) && $stable(first_exp) && $stable(first_act))); // R7

    AST_MASK_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((or_mask & $past(or_mask)) == $past(or_mask))); // R8

endmodule

// File: rtl/mem_pattern_tester.sv
module mem_pattern_tester
    import mpt_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int FIRST_ADDR = 0,
    parameter int LAST_ADDR  = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               req_valid,
    output logic               req_write,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [DATA_W-1:0]  req_wdata,
    input  logic               mem_done,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               done,
    output logic               result_pass,
    output logic               result_fail,
    output logic [ADDR_W-1:0]  fail_addr,
    output logic [DATA_W-1:0]  fail_expected,
    output logic [DATA_W-1:0]  fail_actual,
    output logic [DATA_W-1:0]  fail_bits,
    output logic [1:0]         fault_class
);

    localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(FIRST_ADDR);
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(LAST_ADDR);

    typedef enum logic [2:0] {
        ST_IDLE, ST_WR_REQ, ST_WR_WAIT, ST_RD_REQ, ST_RD_WAIT, ST_PASS_END, ST_FINISH
    } state_e;

    state_e             state_q, state_d;
    pass_e              pass_q, pass_d;
    logic [ADDR_W-1:0]  addr_q, addr_d;
    logic               clr, cmp_en, any_fail, finish_now;
    logic [DATA_W-1:0]  exp_data;
    fault_e             fclass;

    mpt_pattern_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pat (
        .pass_sel (pass_q),
        .addr     (addr_q),
        .exp_data (exp_data)
    );

    mpt_fault_log #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .cmp_en     (cmp_en),
        .addr       (addr_q),
        .exp_data   (exp_data),
        .act_data   (mem_rdata),
        .any_fail   (any_fail),
        .first_addr (fail_addr),
        .first_exp  (fail_expected),
        .first_act  (fail_actual),
        .or_mask    (fail_bits),
        .fclass     (fclass)
    );

    // next-state logic
    always_comb begin
        state_d    = state_q;
        pass_d     = pass_q;
        addr_d     = addr_q;
        clr        = 1'b0;
        cmp_en     = 1'b0;
        finish_now = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    clr     = 1'b1;
                    pass_d  = PASS_WALK;
                    addr_d  = A_FIRST;
                    state_d = ST_WR_REQ;
                end
            end
            ST_WR_REQ: state_d = ST_WR_WAIT;
            ST_WR_WAIT: begin
                if (mem_done) begin
                    if (addr_q == A_LAST) begin
                        addr_d  = A_FIRST;
                        state_d = ST_RD_REQ;
                    end else begin
                        addr_d  = addr_q + ADDR_W'(1);
                        state_d = ST_WR_REQ;
                    end
                end
            end
            ST_RD_REQ: state_d = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (mem_done) begin
                    cmp_en = 1'b1;
                    if (addr_q == A_LAST) begin
                        state_d = ST_PASS_END;
                    end else begin
                        addr_d  = addr_q + ADDR_W'(1);
                        state_d = ST_RD_REQ;
                    end
                end
            end
            ST_PASS_END: begin
                if (any_fail || pass_q == PASS_CHK_B) begin
                    finish_now = 1'b1;
                    state_d    = ST_FINISH;
                end else begin
                    clr     = 1'b1;
                    addr_d  = A_FIRST;
                    pass_d  = (pass_q == PASS_WALK) ? PASS_CHK_A : PASS_CHK_B;
                    state_d = ST_WR_REQ;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pass_q  <= PASS_WALK;
            addr_q  <= A_FIRST;
        end else begin
            state_q <= state_d;
            pass_q  <= pass_d;
            addr_q  <= addr_d;
        end
    end

    // verdict outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_pass <= 1'b0;
            result_fail <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            result_pass <= 1'b0;
            result_fail <= 1'b0;
        end else if (finish_now) begin
            result_pass <= !any_fail;
            result_fail <= any_fail;
        end
    end

    assign req_valid   = (state_q == ST_WR_REQ) || (state_q == ST_RD_REQ);
    assign req_write   = (state_q == ST_WR_REQ);
    assign req_addr    = addr_q;
    assign req_wdata   = exp_data;
    assign done        = (state_q == ST_FINISH);
    assign fault_class = fclass;

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(result_pass && result_fail)); // R5

    AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> ($stable(result_pass) && $stable(result_fail) && $stable(fail_addr))); // R10

    AST_STOP_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS_END && any_fail) |=> done); // R6

endmodule

// File: tb/sim_mem_pattern_tester.sv
`timescale 1ns/1ps
module sim_mem_pattern_tester;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       req_valid, req_write, mem_done, done, result_pass, result_fail;
    logic [3:0] req_addr, fail_addr;
    logic [7:0] req_wdata, mem_rdata, fail_expected, fail_actual, fail_bits;
    logic [1:0] fault_class;

    always #2.5 clk = ~clk;   // 200 MHz

    mem_pattern_tester u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_done(mem_done), .mem_rdata(mem_rdata),
        .done(done), .result_pass(result_pass), .result_fail(result_fail),
        .fail_addr(fail_addr), .fail_expected(fail_expected), .fail_actual(fail_actual),
        .fail_bits(fail_bits), .fault_class(fault_class)
    );

    // fault model: kind 0 none, 1 stuck data line, 2 one cell bit forced, 3 address bit ignored
    logic [1:0] f_kind = '0;
    logic [2:0] f_bit  = '0;
    logic       f_val  = 1'b0;
    logic [3:0] f_addr = '0;
    logic [1:0] lat    = 2'd1;

    logic [7:0] mem [16];
    logic       pend = 1'b0;
    logic [1:0] cnt = '0;
    logic       p_wr = 1'b0;
    logic [3:0] p_addr = '0;
    logic [7:0] p_data = '0;
    int         nreq = 0;
    int         overlap = 0;
    int         n_cmp = 0;
    int         n_bad = 0;
    int         cycles = 0;

    function automatic logic [3:0] phys(logic [3:0] a);
        logic [3:0] p = a;
        if (f_kind == 2'd3) p[f_bit[1:0]] = 1'b0;
        return p;
    endfunction

    function automatic logic [7:0] rd_model(logic [3:0] a);
        logic [7:0] d = mem[phys(a)];
        if (f_kind == 2'd1) d[f_bit] = f_val;
        if (f_kind == 2'd2 && a == f_addr) d[f_bit] = f_val;
        return d;
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            pend     <= 1'b0;
            mem_done <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_done <= 1'b0;
            if (req_valid && pend) overlap <= overlap + 1;
            if (req_valid && !pend) begin
                pend   <= 1'b1;
                cnt    <= lat - 2'd1;
                p_wr   <= req_write;
                p_addr <= req_addr;
                p_data <= req_wdata;
                nreq   <= nreq + 1;
            end else if (pend) begin
                if (cnt == 2'd0) begin
                    pend     <= 1'b0;
                    mem_done <= 1'b1;
                    if (p_wr) mem[phys(p_addr)] <= p_data;
                    else      mem_rdata <= rd_model(p_addr);
                end else begin
                    cnt <= cnt - 2'd1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0] kind;
        logic [2:0] fbit;
        logic       fval;
        logic [3:0] faddr;
        logic [1:0] lat;
        logic       e_pass;
        logic [1:0] e_cls;
        logic [3:0] e_addr;
        logic [7:0] e_exp;
        logic [7:0] e_act;
        logic [7:0] e_mask;
        logic [7:0] e_reqs;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 1'b0, 4'd0, 2'd1, 1'b1, 2'b00, 4'd0, 8'h00, 8'h00, 8'h00, 8'd96},
        '{2'd1, 3'd3, 1'b1, 4'd0, 2'd2, 1'b0, 2'b01, 4'd0, 8'h01, 8'h09, 8'h08, 8'd32},
        '{2'd1, 3'd0, 1'b0, 4'd0, 2'd1, 1'b0, 2'b01, 4'd0, 8'h01, 8'h00, 8'h01, 8'd32},
        '{2'd2, 3'd7, 1'b1, 4'd5, 2'd3, 1'b0, 2'b10, 4'd5, 8'h20, 8'hA0, 8'h80, 8'd32},
        '{2'd3, 3'd0, 1'b0, 4'd0, 2'd1, 1'b0, 2'b11, 4'd0, 8'h01, 8'h02, 8'hFF, 8'd32},
        '{2'd2, 3'd0, 1'b0, 4'd1, 2'd2, 1'b0, 2'b10, 4'd1, 8'h55, 8'h54, 8'h01, 8'd64},
        '{2'd2, 3'd0, 1'b0, 4'd4, 2'd1, 1'b0, 2'b10, 4'd4, 8'h55, 8'h54, 8'h01, 8'd96},
        '{2'd3, 3'd3, 1'b0, 4'd0, 2'd1, 1'b1, 2'b00, 4'd0, 8'h00, 8'h00, 8'h00, 8'd96}
    };

    int dones_seen;

    task automatic launch();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int t = 0; t < 4000; t++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        if (!ok) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R10 watchdog: done never rose actual=0 expected=1");
        end
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL global watchdog actual=%0d expected<150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit ok;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 req_valid in reset", 32'(req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 done after reset", 32'(done), 0);
        chk("R11 pass after reset", 32'(result_pass), 0);
        chk("R11 fail after reset", 32'(result_fail), 0);
        chk("R11 req_valid idle", 32'(req_valid), 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            f_kind = VECS[v].kind;
            f_bit  = VECS[v].fbit;
            f_val  = VECS[v].fval;
            f_addr = VECS[v].faddr;
            lat    = VECS[v].lat;
            nreq   = 0;
            launch();
            wait_done(ok);
            if (ok) begin
                chk($sformatf("R5 pass vec%0d", v), 32'(result_pass), 32'(VECS[v].e_pass));
                chk($sformatf("R6 fail vec%0d", v), 32'(result_fail), 32'(!VECS[v].e_pass));
                chk($sformatf("R6 reqs vec%0d", v), nreq, 32'(VECS[v].e_reqs));
                chk($sformatf("R7 addr vec%0d", v), 32'(fail_addr), 32'(VECS[v].e_addr));
                chk($sformatf("R2 R7 expected vec%0d", v), 32'(fail_expected), 32'(VECS[v].e_exp));
                chk($sformatf("R7 actual vec%0d", v), 32'(fail_actual), 32'(VECS[v].e_act));
                chk($sformatf("R8 mask vec%0d", v), 32'(fail_bits), 32'(VECS[v].e_mask));
                chk($sformatf("R9 class vec%0d", v), 32'(fault_class), 32'(VECS[v].e_cls));
                @(negedge clk);
                chk($sformatf("R10 done width vec%0d", v), 32'(done), 0);
            end
            repeat (3) @(negedge clk);
        end
        chk("R4 overlapping requests", overlap, 0);

        // R10 results hold after a failing run
        f_kind = 2'd2; f_bit = 3'd7; f_val = 1'b1; f_addr = 4'd5; lat = 2'd1;
        launch();
        wait_done(ok);
        repeat (20) @(negedge clk);
        chk("R10 hold fail", 32'(result_fail), 1);
        chk("R10 hold addr", 32'(fail_addr), 5);
        chk("R10 hold class", 32'(fault_class), 2);

        // R10 start clears, R1 start while busy ignored, R3 final contents
        f_kind = 2'd0; nreq = 0; dones_seen = 0;
        launch();
        chk("R10 cleared fail on start", 32'(result_fail), 0);
        chk("R10 cleared addr on start", 32'(fail_addr), 0);
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 800; t++) begin
            if (done) dones_seen++;
            @(negedge clk);
        end
        chk("R1 single done with mid-run start", dones_seen, 1);
        chk("R1 request count with mid-run start", nreq, 96);
        chk("R5 clean verdict", 32'(result_pass), 1);
        for (int a = 0; a < 16; a++)
            chk($sformatf("R3 final word %0d", a), 32'(mem[a]), (a % 2 == 0) ? 32'h55 : 32'hAA);
        chk("R4 overlapping requests end", overlap, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule